// File: doc/BRIEF.md
# Charge-Pump Control with Lock Detect

This block sits between the reference divider and the programmable VCO divider of a frequency synthesizer loop. Running on a fast sample clock, it detects the rising edges of the reference pulse and of the divided VCO pulse. It decides whether the charge pump should source current, sink current or float. When the divided edge comes first, the pump sources until the reference edge arrives. When the reference edge comes first, the pump sinks until the divided edge arrives. Edges seen in the same sample cycle leave the pump floating.

The block also keeps a lock indication. The loop counts as locked after a run of reference periods in which both edges land in the same sample cycle. Any phase pulse drops the lock at once. While the loop is locked, a current-select output steps the pump current from its high setting down to its low one. A registered three-bit test code can override the pump state or route the reference or divided pulse to a shared lock/test pin. A one-bit control switches the tuning-amplifier enable. Reset brings everything to safe defaults.

Top module: `cp_lock_ctrl`

## Requirements
- R1: In normal mode (test code 000 or 001), a divided-pulse rising edge seen with no pending reference edge raises pump_src_o in the following cycle. pump_src_o stays high until the cycle after the reference rising edge is seen, so its width in cycles equals the edge separation.
- R2: In normal mode, a reference rising edge seen first raises pump_snk_o in the following cycle. pump_snk_o stays high until the cycle after the divided rising edge is seen.
- R3: When both rising edges are seen in the same sample cycle, neither pump output rises. pump_src_o and pump_snk_o are never high together.
- R4: lock_o rises in the cycle after the 4th consecutive reference edge that coincides with a divided edge with no phase pulse in between. Any phase pulse restarts the count.
- R5: Any cycle in which only one of the two edges is seen, or in which a phase pulse is pending, clears lock_o in the following cycle.
- R6: cur_hi_o (1 = high pump current, 0 = low) is 1 out of reset. It falls together with lock_o when lock is reached by counting, and returns to 1 when lock is lost.
- R7: The test code takes effect one cycle after it is applied. Codes 010 and 011 force the pump to float, 100 forces sink (pump_snk_o=1), 101 forces source (pump_src_o=1), and 110 and 111 force float.
- R8: lock_pin_o carries lock_o for codes 000 to 101. With code 110 it carries the reference input delayed by one register, and with code 111 it carries the divided input delayed by one register.
- R9: amp_en_o equals the inverse of amp_off_i from the previous cycle (amp_off_i = 0 means the amplifier is on).
- R10: During reset the pump floats, amp_en_o = 0, cur_hi_o = 1, lock_o = 1 and lock_pin_o = 1, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low power-on reset |
| ref_i | input | 1 | Reference pulse |
| div_i | input | 1 | Divided VCO pulse |
| test_mode_i | input | 3 | Test code, MSB first (000/001 normal) |
| amp_off_i | input | 1 | Tuning amplifier control, 1 = off |
| pump_src_o | output | 1 | Pump source enable |
| pump_snk_o | output | 1 | Pump sink enable |
| lock_o | output | 1 | Lock indication, 1 = locked |
| lock_pin_o | output | 1 | Shared lock/test pin |
| cur_hi_o | output | 1 | Pump current select, 1 = high |
| amp_en_o | output | 1 | Tuning amplifier enable |

## Verification
Every result here is due exactly one sample edge after its cause. A pump output, the lock flag and the current select change on the edge that first sees an input edge. A new test code, the amplifier control and the reference or divided value on the test pin each pass through one register. The bench drives inputs on the falling edge and reads outputs on the next falling edge, after exactly one rising edge. Every check therefore lands in the cycle when the result first appears. The pulse-width checks repeat that read on every cycle of a lead or lag, so a pulse that is one cycle early, late or short shows up.

// File: rtl/cp_lock_pkg.sv
package cp_lock_pkg;

   typedef enum logic [1:0] {
      PUMP_FLOAT = 2'b00,
      PUMP_PUSH  = 2'b01,
      PUMP_PULL  = 2'b10,
      PUMP_AUTO  = 2'b11
   } pump_cmd_e;

   typedef enum logic [1:0] {
      PIN_LOCK = 2'b00,
      PIN_REF  = 2'b01,
      PIN_DIV  = 2'b10
   } pin_sel_e;

   typedef struct packed {
      pump_cmd_e pump;
      pin_sel_e  pin;
   } mode_dec_t;

   function automatic mode_dec_t decode_mode(input logic [2:0] code);
      mode_dec_t d;
      d.pin = PIN_LOCK;
      unique casez (code)
         3'b00?:  d.pump = PUMP_AUTO;
         3'b01?:  d.pump = PUMP_FLOAT;
         3'b100:  d.pump = PUMP_PULL;
         3'b101:  d.pump = PUMP_PUSH;
         3'b110: begin d.pump = PUMP_FLOAT; d.pin = PIN_REF; end
         default: begin d.pump = PUMP_FLOAT; d.pin = PIN_DIV; end
      endcase
      return d;
   endfunction

endpackage

// File: rtl/cp_in_sync.sv
module cp_in_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES:0] chain;

   assign chain[0] = d_i;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[g+1] <= 1'b0;
         else        chain[g+1] <= chain[g];
      end
   end

   assign q_o = chain[STAGES];
endmodule

// File: rtl/cp_pfd.sv
module cp_pfd (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_i,
   input  logic div_i,
   output logic ref_edge_o,
   output logic div_edge_o,
   output logic ref_q_o,
   output logic div_q_o,
   output logic up_o,
   output logic dn_o
);
   logic ref_q, div_q, up_q, dn_q;
   logic up_nx, dn_nx;

   assign ref_edge_o = ref_i & ~ref_q;
   assign div_edge_o = div_i & ~div_q;
   assign up_nx      = up_q | div_edge_o;
   assign dn_nx      = dn_q | ref_edge_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= 1'b0;
         div_q <= 1'b0;
         up_q  <= 1'b0;
         dn_q  <= 1'b0;
      end else begin
         ref_q <= ref_i;
         div_q <= div_i;
         if (up_nx && dn_nx) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
         end else begin
            up_q <= up_nx;
            dn_q <= dn_nx;
         end
      end
   end

   assign ref_q_o = ref_q;
   assign div_q_o = div_q;
   assign up_o    = up_q;
   assign dn_o    = dn_q;
endmodule

// File: rtl/cp_lock_det.sv
module cp_lock_det #(
   parameter int LOCK_PERIODS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_edge_i,
   input  logic div_edge_i,
   input  logic up_i,
   input  logic dn_i,
   output logic lock_o,
   output logic cur_lo_o
);
   localparam int CNT_W = $clog2(LOCK_PERIODS + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_PERIODS - 1);

   logic [CNT_W-1:0] good_cnt;
   logic             lock_q, cur_lo_q, err_now;

   assign err_now = up_i | dn_i | (ref_edge_i ^ div_edge_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         good_cnt <= '0;
         lock_q   <= 1'b1;
         cur_lo_q <= 1'b0;
      end else if (err_now) begin
         good_cnt <= '0;
         lock_q   <= 1'b0;
         cur_lo_q <= 1'b0;
      end else if (ref_edge_i) begin
         if (good_cnt == LAST) begin
            lock_q   <= 1'b1;
            cur_lo_q <= 1'b1;
         end else begin
            good_cnt <= good_cnt + 1'b1;
         end
      end
   end

   assign lock_o   = lock_q;
   assign cur_lo_o = cur_lo_q;
endmodule

// File: rtl/cp_out_mux.sv
module cp_out_mux
   import cp_lock_pkg::*;
#(
   parameter int MODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              amp_off_i,
   input  logic              up_i,
   input  logic              dn_i,
   input  logic              lock_i,
   input  logic              ref_q_i,
   input  logic              div_q_i,
   output logic [MODE_W-1:0] mode_q_o,
   output logic              src_o,
   output logic              snk_o,
   output logic              pin_o,
   output logic              amp_en_o
);
   logic [MODE_W-1:0] mode_q;
   logic              amp_en_q;
   mode_dec_t         dec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= '0;
         amp_en_q <= 1'b0;
      end else begin
         mode_q   <= mode_i;
         amp_en_q <= ~amp_off_i;
      end
   end

   assign dec = decode_mode(mode_q[2:0]);

   always_comb begin
      unique case (dec.pump)
         PUMP_AUTO:  begin src_o = up_i;  snk_o = dn_i;  end
         PUMP_PUSH:  begin src_o = 1'b1;  snk_o = 1'b0;  end
         PUMP_PULL:  begin src_o = 1'b0;  snk_o = 1'b1;  end
         default:    begin src_o = 1'b0;  snk_o = 1'b0;  end
      endcase
   end

   always_comb begin
      unique case (dec.pin)
         PIN_REF: pin_o = ref_q_i;
         PIN_DIV: pin_o = div_q_i;
         default: pin_o = lock_i;
      endcase
   end

   assign mode_q_o = mode_q;
   assign amp_en_o = amp_en_q;
endmodule

// File: rtl/cp_lock_ctrl.sv
module cp_lock_ctrl #(
   parameter int LOCK_PERIODS = 4,
   parameter int SYNC_STAGES  = 0,
   parameter int MODE_W       = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_i,
   input  logic              div_i,
   input  logic [MODE_W-1:0] test_mode_i,
   input  logic              amp_off_i,
   output logic              pump_src_o,
   output logic              pump_snk_o,
   output logic              lock_o,
   output logic              lock_pin_o,
   output logic              cur_hi_o,
   output logic              amp_en_o
);
   if (LOCK_PERIODS < 1) begin : g_bad_lock
      $error("LOCK_PERIODS must be at least 1");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 0..3");
   end
   if (MODE_W != 3) begin : g_bad_mode
      $error("MODE_W must be 3");
   end

   logic ref_s, div_s;
   logic ref_edge, div_edge, ref_q, div_q, up, dn;
   logic lock_w, cur_lo;
   logic [MODE_W-1:0] mode_q;

   cp_in_sync #(.STAGES(SYNC_STAGES)) u_sync_ref (
      .clk(clk), .rst_n(rst_n), .d_i(ref_i), .q_o(ref_s));
   cp_in_sync #(.STAGES(SYNC_STAGES)) u_sync_div (
      .clk(clk), .rst_n(rst_n), .d_i(div_i), .q_o(div_s));

   cp_pfd u_pfd (
      .clk(clk), .rst_n(rst_n), .ref_i(ref_s), .div_i(div_s),
      .ref_edge_o(ref_edge), .div_edge_o(div_edge),
      .ref_q_o(ref_q), .div_q_o(div_q), .up_o(up), .dn_o(dn));

   cp_lock_det #(.LOCK_PERIODS(LOCK_PERIODS)) u_lock (
      .clk(clk), .rst_n(rst_n), .ref_edge_i(ref_edge), .div_edge_i(div_edge),
      .up_i(up), .dn_i(dn), .lock_o(lock_w), .cur_lo_o(cur_lo));

   cp_out_mux #(.MODE_W(MODE_W)) u_mux (
      .clk(clk), .rst_n(rst_n), .mode_i(test_mode_i), .amp_off_i(amp_off_i),
      .up_i(up), .dn_i(dn), .lock_i(lock_w), .ref_q_i(ref_q), .div_q_i(div_q),
      .mode_q_o(mode_q), .src_o(pump_src_o), .snk_o(pump_snk_o),
      .pin_o(lock_pin_o), .amp_en_o(amp_en_o));

   assign lock_o   = lock_w;
   assign cur_hi_o = ~cur_lo;
endmodule

// File: rtl/cp_lock_ctrl_chk.sv
module cp_lock_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       amp_off_i,
   input logic       pump_src_o,
   input logic       pump_snk_o,
   input logic       lock_o,
   input logic       cur_hi_o,
   input logic       amp_en_o,
   input logic [2:0] mode_q
);
   // R3: pump never drives both directions
   a_r3_pump_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(pump_src_o && pump_snk_o));

   // R5: a phase pulse in normal mode means not locked
   a_r5_pulse_clears_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2:1] == 2'b00 && (pump_src_o || pump_snk_o)) |-> !lock_o);

   // R6: low current only while locked
   a_r6_low_current_locked: assert property (@(posedge clk) disable iff (!rst_n)
      !cur_hi_o |-> lock_o);

   // R7: forced pump states
   a_r7_forced_sink: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 3'b100) |-> (pump_snk_o && !pump_src_o));
   a_r7_forced_source: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 3'b101) |-> (pump_src_o && !pump_snk_o));
   a_r7_forced_float: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2:1] == 2'b01 || mode_q[2:1] == 2'b11) |-> (!pump_src_o && !pump_snk_o));

   // R9: amplifier enable follows inverted control one cycle later
   a_r9_amp_off: assert property (@(posedge clk) disable iff (!rst_n)
      amp_off_i |=> !amp_en_o);
   a_r9_amp_on: assert property (@(posedge clk) disable iff (!rst_n)
      !amp_off_i |=> amp_en_o);

   // R10: defaults while in reset
   a_r10_reset_state: assert property (@(posedge clk)
      !rst_n |=> (!pump_src_o && !pump_snk_o && lock_o && cur_hi_o && !amp_en_o));
endmodule

bind cp_lock_ctrl cp_lock_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .amp_off_i(amp_off_i),
   .pump_src_o(pump_src_o), .pump_snk_o(pump_snk_o), .lock_o(lock_o),
   .cur_hi_o(cur_hi_o), .amp_en_o(amp_en_o), .mode_q(mode_q[2:0]));

// File: tb/cp_lock_ctrl_test.sv
`timescale 1ns/1ps
module cp_lock_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_i = 1'b0;
   logic       div_i = 1'b0;
   logic [2:0] test_mode_i = 3'b100;
   logic       amp_off_i = 1'b0;
   logic       pump_src_o, pump_snk_o, lock_o, lock_pin_o, cur_hi_o, amp_en_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   cp_lock_ctrl uut (
      .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .div_i(div_i),
      .test_mode_i(test_mode_i), .amp_off_i(amp_off_i),
      .pump_src_o(pump_src_o), .pump_snk_o(pump_snk_o), .lock_o(lock_o),
      .lock_pin_o(lock_pin_o), .cur_hi_o(cur_hi_o), .amp_en_o(amp_en_o));

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic t_reset();
      step(); step();
      chk("R10 src in reset", pump_src_o, 1'b0);
      chk("R10 snk in reset", pump_snk_o, 1'b0);
      chk("R10 lock in reset", lock_o, 1'b1);
      chk("R10 pin in reset", lock_pin_o, 1'b1);
      chk("R10 cur_hi in reset", cur_hi_o, 1'b1);
      chk("R10 amp_en in reset", amp_en_o, 1'b0);
      test_mode_i = 3'b000;
      step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic t_amp();
      amp_off_i = 1'b1; step();
      chk("R9 amp off", amp_en_o, 1'b0);
      amp_off_i = 1'b0; step();
      chk("R9 amp on", amp_en_o, 1'b1);
   endtask

   task automatic t_lead(input int d);
      div_i = 1'b1;
      for (int i = 0; i < d; i++) begin
         step();
         chk("R1 source during lead", pump_src_o, 1'b1);
         chk("R1 no sink during lead", pump_snk_o, 1'b0);
         chk("R5 lock low on lead", lock_o, 1'b0);
         chk("R8 pin follows lock", lock_pin_o, 1'b0);
         chk("R6 high current unlocked", cur_hi_o, 1'b1);
      end
      ref_i = 1'b1; step();
      chk("R1 source ends", pump_src_o, 1'b0);
      chk("R1 sink stays low", pump_snk_o, 1'b0);
      ref_i = 1'b0; div_i = 1'b0; step(); step();
   endtask

   task automatic t_lag(input int d);
      ref_i = 1'b1;
      for (int i = 0; i < d; i++) begin
         step();
         chk("R2 sink during lag", pump_snk_o, 1'b1);
         chk("R2 no source during lag", pump_src_o, 1'b0);
         chk("R5 lock low on lag", lock_o, 1'b0);
         chk("R6 high current on lag", cur_hi_o, 1'b1);
      end
      div_i = 1'b1; step();
      chk("R2 sink ends", pump_snk_o, 1'b0);
      chk("R2 source stays low", pump_src_o, 1'b0);
      ref_i = 1'b0; div_i = 1'b0; step(); step();
   endtask

   task automatic t_coin(input int k, input int lock_at);
      for (int i = 1; i <= k; i++) begin
         ref_i = 1'b1; div_i = 1'b1; step();
         chk("R3 no source on coincidence", pump_src_o, 1'b0);
         chk("R3 no sink on coincidence", pump_snk_o, 1'b0);
         chk("R4 lock count", lock_o, (i >= lock_at) ? 1'b1 : 1'b0);
         chk("R6 current select", cur_hi_o, (i >= lock_at) ? 1'b0 : 1'b1);
         ref_i = 1'b0; div_i = 1'b0; step(); step();
      end
   endtask

   task automatic t_modes();
      test_mode_i = 3'b010; div_i = 1'b1; step();
      chk("R7 code 010 floats src", pump_src_o, 1'b0);
      chk("R7 code 010 floats snk", pump_snk_o, 1'b0);
      ref_i = 1'b1; step();
      ref_i = 1'b0; div_i = 1'b0; step();
      test_mode_i = 3'b011; step();
      chk("R7 code 011 floats", pump_src_o | pump_snk_o, 1'b0);
      test_mode_i = 3'b100; step();
      chk("R7 code 100 sink", pump_snk_o, 1'b1);
      chk("R7 code 100 no source", pump_src_o, 1'b0);
      chk("R8 code 100 pin is lock", lock_pin_o, 1'b0);
      test_mode_i = 3'b101; step();
      chk("R7 code 101 source", pump_src_o, 1'b1);
      chk("R7 code 101 no sink", pump_snk_o, 1'b0);
      test_mode_i = 3'b110; step();
      chk("R8 code 110 pin ref low", lock_pin_o, 1'b0);
      ref_i = 1'b1; step();
      chk("R8 code 110 pin ref high", lock_pin_o, 1'b1);
      chk("R7 code 110 floats with pending sink", pump_snk_o, 1'b0);
      ref_i = 1'b0; step();
      chk("R8 code 110 pin ref back low", lock_pin_o, 1'b0);
      test_mode_i = 3'b111; step();
      chk("R8 code 111 pin div low", lock_pin_o, 1'b0);
      div_i = 1'b1; step();
      chk("R8 code 111 pin div high", lock_pin_o, 1'b1);
      div_i = 1'b0; step();
      chk("R8 code 111 pin div back low", lock_pin_o, 1'b0);
      test_mode_i = 3'b001; step();
      chk("R7 code 001 normal idle", pump_src_o | pump_snk_o, 1'b0);
      chk("R8 code 001 pin is lock", lock_pin_o, lock_o);
   endtask

   initial begin
      t_reset();
      t_amp();
      t_lead(3);
      t_lag(2);
      t_coin(4, 4);
      chk("R8 pin shows lock high", lock_pin_o, 1'b1);
      t_lag(1);
      t_coin(2, 99);
      t_lead(1);
      t_coin(4, 4);
      t_modes();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule